// File: doc/BRIEF.md
# Buffered Serial Port with Hardware Handshake

This block is an asynchronous serial transmitter and receiver. Each direction has a 16-byte queue. Software reaches it through a small register port: it writes bytes to send, reads bytes received, sets the line rate and picks a receive fill threshold. An interrupt request rises when the receive queue holds at least the chosen number of bytes.

The line rate comes from a 16x oversampling tick. An integer clock divisor sets the tick period. A fractional term adds one clock to some tick periods: an accumulator is incremented on every tick, and when it wraps modulo a multiplier value, the next tick period gets one extra clock. This lets common rates be reached from clock frequencies that are not a multiple of the rate.

Flow control can be switched on. The block then holds its request-to-send line inactive while the receive queue is at or above the threshold. It also refuses to start a new character while the clear-to-send input is inactive. Both handshake pins are active low.

Top module: `uart_fifo_fc`

## Requirements
- R1: Each queue holds 16 bytes. A data write while the transmit queue is full sets the overrun flag and discards the byte. A character that arrives while the receive queue is full also sets the overrun flag and is discarded.
- R2: A character on the line is one low start bit, then 8 data bits with bit 0 first, then one high stop bit. With the output looped back to the input, bytes come back unchanged and in the order they were written.
- R3: The register at address 3 holds the divisor low byte and address 4 holds the high byte. Address 5 holds the multiplier in bits 7:4 and the fractional add in bits 3:0. One bit lasts 16 ticks. A tick period is the divisor in clocks, plus one clock after each accumulator wrap. Divisor 3, multiplier 4 and add 1 give a bit of 52 clocks. The same setting with add 0 gives 48 clocks.
- R4: Bits 4:3 of the control register (address 1) select the receive threshold: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. Output irq is high exactly when the receive count is at or above the threshold.
- R5: When bit 5 of the control register (automatic flow) is set, rtsN is high while the receive count is at or above the threshold and low otherwise. When that bit is clear, rtsN stays low.
- R6: With automatic flow on and ctsN high, no new start bit appears on txd.
- R7: Writing the control register with bit 1 set empties the receive queue. Writing it with bit 2 set empties the transmit queue, and the discarded bytes are never sent.
- R8: When bit 0 of the control register (queue enable) is 0, each queue holds one byte. A second data write before the first byte is sent sets the overrun flag.
- R9: A stop bit sampled low sets the framing flag, and the character is discarded.
- R10: A read of address 0 pops and returns the oldest received byte. A read of address 2 returns the status: bit 0 receive not empty, bit 1 transmit full, bit 2 overrun, bit 3 framing, bit 4 irq, bit 5 transmitter idle. The status read clears bits 2 and 3. Read data appears on rdData in the cycle after the read strobe.
- R11: After reset, txd is 1, irq is 0, rtsN is 0 and the status reads 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |
| ctsN | input | 1 | Clear to send, active low |
| rtsN | output | 1 | Request to send, active low |
| irq | output | 1 | Receive threshold request |

## Verification
The assertions assume that rstN is held low for some cycles and that the register port never strobes a read and a write in the same cycle. They also assume rxd idles high outside a character. The bench keeps to these assumptions: it drives the register strobes from one task at a time, on the falling edge. It changes ctsN only while the transmitter is idle. It drives rxd by hand only during a single frame, whose bit length matches the programmed rate.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  // Register addresses of the software port
  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_CTRL = 3'd1,
    A_STAT = 3'd2,
    A_DIVL = 3'd3,
    A_DIVH = 3'd4,
    A_FRAC = 3'd5
  } regAddrT;

  // Strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txShift;
    logic flushTx;
    logic rxPush;
    logic rxPop;
    logic rxShift;
    logic flushRx;
  } strobeT;
endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [7:0]    din,
  output logic [7:0]    head,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      count <= count + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

  assign head = mem[rp];
endmodule

// File: rtl/uart_fc_dp.sv
module uart_fc_dp import uart_fc_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [7:0]    wrByte,
  input  logic          rxd,
  output logic          txd,
  output logic          rxBit,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [7:0]    rxHead
);
  logic [7:0] txHead, rxSh;
  logic [9:0] txSh;
  logic [1:0] rxSync;

  uart_fc_fifo #(.DEPTH(DEPTH), .CW(CW)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.txPop), .flush(stb.flushTx),
    .din(wrByte), .head(txHead), .count(txCount));

  uart_fc_fifo #(.DEPTH(DEPTH), .CW(CW)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pop(stb.rxPop), .flush(stb.flushRx),
    .din(rxSh), .head(rxHead), .count(rxCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '1;
      rxSh <= '0;
      rxSync <= 2'b11;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (stb.txPop) txSh <= {1'b1, txHead, 1'b0};
      else if (stb.txShift) txSh <= {1'b1, txSh[9:1]};
      if (stb.rxShift) rxSh <= {rxBit, rxSh[7:1]};
    end
  end

  assign txd = txSh[0];
  assign rxBit = rxSync[1];
endmodule

// File: rtl/uart_fc_ctrl.sv
module uart_fc_ctrl import uart_fc_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH) + 1,
  parameter logic [15:0] DIV_INIT = 16'd1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [2:0]    addr,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdData,
  input  logic          ctsN,
  output logic          rtsN,
  output logic          irq,
  input  logic          rxBit,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [7:0]    rxHead,
  output strobeT        stb
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic fifoEn, autoFlow, ovr, fer;
  logic [1:0] trigSel;
  logic [15:0] divisor, bCnt;
  logic [3:0] mulVal, divAdd, acc;
  logic extra, tick, wrap;
  logic [16:0] limit;
  logic [4:0] accSum, accNext;
  logic [CW-1:0] cap, lvlSel, lvl;
  logic txFull, rxFull, txIdle, ctsOk, txStart, rxMid, rxEnd;
  logic txBusy, rxBusy;
  logic [3:0] txTick, txBits, rxTick, rxBits;

  // Fractional tick generator
  always_comb begin
    limit = {1'b0, (divisor == 16'd0) ? 16'd1 : divisor} - 17'd1 + {16'd0, extra};
    tick = {1'b0, bCnt} >= limit;
    accSum = {1'b0, acc} + {1'b0, divAdd};
    wrap = (mulVal != 4'd0) && (accSum >= {1'b0, mulVal});
    accNext = wrap ? accSum - {1'b0, mulVal} : accSum;
  end

  // Capacity, threshold and handshake
  always_comb begin
    cap = fifoEn ? FULL : CW'(1);
    case (trigSel)
      2'd0: lvlSel = CW'(1);
      2'd1: lvlSel = CW'(4);
      2'd2: lvlSel = CW'(8);
      default: lvlSel = CW'(14);
    endcase
    lvl = fifoEn ? lvlSel : CW'(1);
    txFull = txCount >= cap;
    rxFull = rxCount >= cap;
    txIdle = !txBusy && (txCount == '0);
    irq = rxCount >= lvl;
    rtsN = autoFlow && irq;
    ctsOk = !autoFlow || !ctsN;
  end

  // Strobes to the datapath
  always_comb begin
    txStart = !txBusy && tick && (txCount != '0) && ctsOk;
    rxMid = rxBusy && tick && (rxTick == 4'd7);
    rxEnd = rxMid && (rxBits == 4'd9);
    stb = '0;
    stb.txPush = wrEn && (addr == A_DATA) && !txFull;
    stb.txPop = txStart;
    stb.txShift = txBusy && tick && (txTick == 4'd15) && (txBits != 4'd9);
    stb.flushTx = wrEn && (addr == A_CTRL) && wrData[2];
    stb.flushRx = wrEn && (addr == A_CTRL) && wrData[1];
    stb.rxPop = rdEn && (addr == A_DATA) && (rxCount != '0);
    stb.rxShift = rxMid && (rxBits >= 4'd1) && (rxBits <= 4'd8);
    stb.rxPush = rxEnd && rxBit && !rxFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn <= 1'b1;
      trigSel <= 2'd0;
      autoFlow <= 1'b0;
      divisor <= DIV_INIT;
      mulVal <= 4'd1;
      divAdd <= 4'd0;
      bCnt <= '0;
      acc <= '0;
      extra <= 1'b0;
      ovr <= 1'b0;
      fer <= 1'b0;
      rdData <= '0;
      txBusy <= 1'b0;
      txTick <= '0;
      txBits <= '0;
      rxBusy <= 1'b0;
      rxTick <= '0;
      rxBits <= '0;
    end else begin
      if (tick) begin
        bCnt <= '0;
        acc <= accNext[3:0];
        extra <= wrap;
      end else begin
        bCnt <= bCnt + 16'd1;
      end

      if (wrEn) begin
        case (addr)
          A_CTRL: begin
            fifoEn <= wrData[0];
            trigSel <= wrData[4:3];
            autoFlow <= wrData[5];
          end
          A_DIVL: divisor[7:0] <= wrData;
          A_DIVH: divisor[15:8] <= wrData;
          A_FRAC: begin
            mulVal <= wrData[7:4];
            divAdd <= wrData[3:0];
          end
          default: ;
        endcase
      end

      ovr <= ((wrEn && (addr == A_DATA) && txFull) || (rxEnd && rxBit && rxFull))
             || (ovr && !(rdEn && (addr == A_STAT)));
      fer <= (rxEnd && !rxBit) || (fer && !(rdEn && (addr == A_STAT)));

      if (rdEn) begin
        case (addr)
          A_DATA: rdData <= (rxCount != '0) ? rxHead : 8'd0;
          A_CTRL: rdData <= {2'b00, autoFlow, trigSel, 2'b00, fifoEn};
          A_STAT: rdData <= {2'b00, txIdle, irq, fer, ovr, txFull, rxCount != '0};
          A_DIVL: rdData <= divisor[7:0];
          A_DIVH: rdData <= divisor[15:8];
          A_FRAC: rdData <= {mulVal, divAdd};
          default: rdData <= 8'd0;
        endcase
      end

      if (txStart) begin
        txBusy <= 1'b1;
        txTick <= '0;
        txBits <= '0;
      end else if (txBusy && tick) begin
        txTick <= txTick + 4'd1;
        if (txTick == 4'd15) begin
          if (txBits == 4'd9) txBusy <= 1'b0;
          else txBits <= txBits + 4'd1;
        end
      end

      if (!rxBusy) begin
        if (tick && !rxBit) begin
          rxBusy <= 1'b1;
          rxTick <= '0;
          rxBits <= '0;
        end
      end else if (tick) begin
        rxTick <= rxTick + 4'd1;
        if (rxTick == 4'd7) begin
          if (((rxBits == 4'd0) && rxBit) || (rxBits == 4'd9)) rxBusy <= 1'b0;
          rxBits <= rxBits + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_fifo_fc.sv
module uart_fifo_fc import uart_fc_pkg::*; #(
  parameter int DEPTH = 16,
  parameter logic [15:0] DIV_INIT = 16'd1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       txd,
  input  logic       rxd,
  input  logic       ctsN,
  output logic       rtsN,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  strobeT stb;
  logic [CW-1:0] txCount, rxCount;
  logic [7:0] rxHead;
  logic rxBit;

  uart_fc_ctrl #(.DEPTH(DEPTH), .CW(CW), .DIV_INIT(DIV_INIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ctsN(ctsN), .rtsN(rtsN), .irq(irq), .rxBit(rxBit),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead), .stb(stb));

  uart_fc_dp #(.DEPTH(DEPTH), .CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(wrData), .rxd(rxd), .txd(txd),
    .rxBit(rxBit), .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead));
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk import uart_fc_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          txd,
  input logic          rtsN,
  input logic          irq,
  input strobeT        stb,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount
);
  p_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxPush |-> rxCount < CW'(DEPTH));

  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.txPop |-> txCount != '0);

  p_txd_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txd) |-> $past(stb.txPop || stb.txShift));

  p_rts_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    rtsN |-> irq);

  p_flush_rx_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.flushRx |=> rxCount == '0);
endmodule

bind uart_fifo_fc uart_fc_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .txd(txd), .rtsN(rtsN), .irq(irq), .stb(stb),
  .txCount(txCount), .rxCount(rxCount));

// File: tb/uart_fifo_fc_tb.sv
module uart_fifo_fc_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic txd, rtsN, irq;
  logic ctsN = 1'b0;
  logic loopEn = 1'b1;
  logic benchRxd = 1'b1;
  logic rxd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit afLive = 0;
  bit ctsHold = 0;
  bit monOn = 0;
  byte unsigned expQ[$];

  assign rxd = loopEn ? txd : benchRxd;

  always #5 clk = ~clk;

  uart_fifo_fc dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .txd(txd), .rxd(rxd), .ctsN(ctsN), .rtsN(rtsN), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic send(input byte unsigned b);
    wr(3'd0, b);
    expQ.push_back(b);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Per-clock model of the handshake output (R5) and CTS gating (R6)
  always @(posedge clk) begin
    #2;
    if (rstN && monOn) begin
      if (wrEn && addr == 3'd1) afLive = wrData[5];
      check(rtsN == (afLive ? irq : 1'b0), "R5 rts model", rtsN, afLive ? irq : 1'b0);
      if (ctsHold) check(txd == 1'b1, "R6 txd idle while cts off", txd, 1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    check(txd == 1'b1, "R11 txd", txd, 1);
    check(irq == 1'b0, "R11 irq", irq, 0);
    check(rtsN == 1'b0, "R11 rtsN", rtsN, 0);
    rd(3'd2, d);
    check(d == 8'h20, "R11 status", d, 8'h20);
    monOn = 1;

    // R3: fractional rate, divisor 3, mul 4, add 1
    wr(3'd3, 8'd3);
    wr(3'd4, 8'd0);
    wr(3'd5, 8'h41);
    wr(3'd1, 8'h01);
    send(8'h55);
    while (txd) @(negedge clk);
    n = 0;
    while (!txd) begin @(negedge clk); n++; end
    check(n == 52, "R3 bit width fractional", n, 52);
    waitClk(700);
    rd(3'd0, d);
    check(d == expQ.pop_front(), "R2 single byte", d, 8'h55);

    // R3: integer-only rate
    wr(3'd5, 8'h40);
    waitClk(20);
    send(8'h55);
    while (txd) @(negedge clk);
    n = 0;
    while (!txd) begin @(negedge clk); n++; end
    check(n == 48, "R3 bit width integer", n, 48);
    waitClk(700);
    rd(3'd0, d);
    check(d == expQ.pop_front(), "R2 single byte integer rate", d, 8'h55);
    wr(3'd5, 8'h41);

    // R2: several patterns, in order
    send(8'h00); send(8'hFF); send(8'hA5); send(8'h3C); send(8'h81);
    waitClk(5 * 600 + 300);
    for (int i = 0; i < 5; i++) begin
      byte unsigned e;
      e = expQ.pop_front();
      rd(3'd0, d);
      check(d == e, "R2 loopback data", d, e);
    end
    rd(3'd2, d);
    check(d[0] == 1'b0, "R10 rx empty after reads", d[0], 0);

    // R4/R5/R7: each threshold level, with automatic flow on
    ctsN = 1'b0;
    for (int s = 0; s < 4; s++) begin
      int lvl;
      logic [7:0] cv;
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      cv = 8'h21 | 8'(s << 3);
      wr(3'd1, cv);
      for (int i = 0; i < lvl - 1; i++) wr(3'd0, 8'(i + 1));
      waitClk(lvl * 600 + 300);
      check(irq == 1'b0, "R4 below threshold", irq, 0);
      wr(3'd0, 8'hE7);
      waitClk(900);
      check(irq == 1'b1, "R4 threshold reached", irq, 1);
      check(rtsN == 1'b1, "R5 rts off at threshold", rtsN, 1);
      rd(3'd0, d);
      waitClk(2);
      check(irq == 1'b0, "R4 below after pop", irq, 0);
      check(rtsN == 1'b0, "R5 rts back on", rtsN, 0);
      wr(3'd1, cv | 8'h02);
      rd(3'd2, d);
      check(d[0] == 1'b0, "R7 rx flush empties", d[0], 0);
    end

    // R6: transmit held while cts is off
    wr(3'd1, 8'h21);
    ctsN = 1'b1; ctsHold = 1;
    send(8'hC3);
    waitClk(1500);
    rd(3'd2, d);
    check(d[5] == 1'b0, "R6 byte still pending", d[5], 0);
    ctsHold = 0; ctsN = 1'b0;
    waitClk(800);
    rd(3'd0, d);
    check(d == expQ.pop_front(), "R6 byte sent after release", d, 8'hC3);

    // R1/R10: transmit overrun and flag clear
    ctsN = 1'b1; ctsHold = 1;
    for (int i = 0; i < 16; i++) send(8'(8'h10 + i));
    rd(3'd2, d);
    check(d[1] == 1'b1, "R1 tx full at 16", d[1], 1);
    check(d[2] == 1'b0, "R1 no overrun yet", d[2], 0);
    wr(3'd0, 8'h99);
    rd(3'd2, d);
    check(d[2] == 1'b1, "R1 overrun set", d[2], 1);
    rd(3'd2, d);
    check(d[2] == 1'b0, "R10 overrun cleared by read", d[2], 0);
    ctsHold = 0; ctsN = 1'b0;
    waitClk(16 * 600 + 300);
    for (int i = 0; i < 16; i++) begin
      byte unsigned e;
      e = expQ.pop_front();
      rd(3'd0, d);
      check(d == e, "R1 sixteen bytes kept", d, e);
    end
    rd(3'd2, d);
    check(d[0] == 1'b0, "R1 extra byte dropped", d[0], 0);

    // R7: transmit flush
    ctsN = 1'b1; ctsHold = 1;
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    wr(3'd1, 8'h25);
    rd(3'd2, d);
    check(d[5] == 1'b1, "R7 tx idle after flush", d[5], 1);
    ctsHold = 0; ctsN = 1'b0;
    waitClk(1000);
    rd(3'd2, d);
    check(d[0] == 1'b0, "R7 flushed bytes not sent", d[0], 0);

    // R8: queues disabled hold one byte
    wr(3'd1, 8'h20);
    ctsN = 1'b1; ctsHold = 1;
    send(8'h6E);
    wr(3'd0, 8'h17);
    rd(3'd2, d);
    check(d[2] == 1'b1, "R8 overrun on second byte", d[2], 1);
    ctsHold = 0; ctsN = 1'b0;
    waitClk(800);
    rd(3'd0, d);
    check(d == expQ.pop_front(), "R8 first byte delivered", d, 8'h6E);
    rd(3'd2, d);
    check(d[0] == 1'b0, "R8 second byte dropped", d[0], 0);

    // R9: framing error from a low stop bit
    wr(3'd1, 8'h01);
    loopEn = 1'b0;
    benchRxd = 1'b0; waitClk(52);
    for (int b = 0; b < 8; b++) begin
      benchRxd = (8'h5A >> b) & 1;
      waitClk(52);
    end
    benchRxd = 1'b0; waitClk(52);
    benchRxd = 1'b1; waitClk(400);
    rd(3'd2, d);
    check(d[3] == 1'b1, "R9 framing flag", d[3], 1);
    check(d[0] == 1'b0, "R9 byte discarded", d[0], 0);
    rd(3'd2, d);
    check(d[3] == 1'b0, "R10 framing cleared by read", d[3], 0);
    loopEn = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule